// File: doc/BRIEF.md
# Gapped-Clock Smoothing Buffer

This block evens out the timing of a dual-rail line bit stream whose write strobe arrives in bursts, with some strobe periods missing and the rest crowded closer together. Each incoming bit (a positive-rail and a negative-rail flag) goes into a small elastic store. A phase-accumulator oscillator, clocked from the fast reference `clk`, reads the bits out again. The oscillator adds a fixed nominal increment every reference cycle, plus a correction taken from how far the store's fill level sits from its centre. When the store fills up, reads speed up; when it drains, they slow down. The output strobe therefore comes out regular.

Two lanes pass through the block: a transmit lane and a receive lane. A single lane-select input puts the store into one of the two lanes, or into neither. The lane that is not selected passes straight through on the same cycle. So do both lanes when the block is disabled. The store depth can be 32 or 64 entries. The correction gain can be chosen from four settings. A fixed-configuration input overrides both and forces the deepest store and the weakest correction. Two sticky flags report writes into a full store and reads from an empty one. After either event the store is recentred.

Top module: `gap_smoother`

## Requirements
- R1: While `en` is low, or `lane_sel` is 0 or 3, each lane output (strobe, positive rail, negative rail) equals the same lane's input in the same cycle. Both buffered-output strobes stay low one cycle after the block stops running.
- R2: `lane_sel` = 1 routes the transmit lane through the store and passes the receive lane straight through. `lane_sel` = 2 does the opposite.
- R3: The store holds 64 entries when `cfg_fixed` or `cfg_deep` is high, and 32 entries otherwise. A run of 24 back-to-back writes from the recentred state overflows the 32-entry store but not the 64-entry store.
- R4: While the block runs, it holds the read position half the depth behind the write position. If no overflow or underflow occurs, read number j after start (counting from 0) returns the rails of write number j − depth/2. The rails appear on the lane outputs together with the output strobe.
- R5: A write while the store is full and no read happens in the same cycle sets `ovf_flag` and recentres the store to half full.
- R6: A read while the store is empty sets `unf_flag` and recentres the store. A 12-UI write gap leaves the 32-entry store without underflow. A 400-cycle gap underflows it.
- R7: Both flags stay set while the block keeps running. Both clear in the cycle after it stops running.
- R8: With the fill level at centre, the read oscillator adds its nominal increment (one read every 8 reference cycles with the default parameters). Reads never come on two consecutive cycles, and none come while the block is stopped.
- R9: `bw_sel` sets a right shift on the fill-error correction: 0 gives the strongest correction and 3 the weakest. `cfg_fixed` forces shift 3. During a write gap, shift 0 therefore yields fewer reads than shift 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable for the smoothing function |
| lane_sel | input | 2 | 0/3 neither, 1 transmit lane, 2 receive lane |
| cfg_fixed | input | 1 | Forces 64 entries and weakest correction |
| cfg_deep | input | 1 | 1 selects 64 entries, 0 selects 32 |
| bw_sel | input | 2 | Correction shift, 0 strongest to 3 weakest |
| tx_stb | input | 1 | Transmit-lane input bit strobe (gapped) |
| tx_pos | input | 1 | Transmit-lane positive rail |
| tx_neg | input | 1 | Transmit-lane negative rail |
| rx_stb | input | 1 | Receive-lane input bit strobe (gapped) |
| rx_pos | input | 1 | Receive-lane positive rail |
| rx_neg | input | 1 | Receive-lane negative rail |
| tx_out_stb | output | 1 | Transmit-lane output strobe |
| tx_out_pos | output | 1 | Transmit-lane output positive rail |
| tx_out_neg | output | 1 | Transmit-lane output negative rail |
| rx_out_stb | output | 1 | Receive-lane output strobe |
| rx_out_pos | output | 1 | Receive-lane output positive rail |
| rx_out_neg | output | 1 | Receive-lane output negative rail |
| ovf_flag | output | 1 | Sticky overflow indication |
| unf_flag | output | 1 | Sticky underflow indication |

## Verification
The bench logs every bit it writes and compares each smoothed read against the bit written half a depth earlier. A design with an off-by-one start offset, or with stale read data, fails at once. Bursts and gaps near the edge separate the two depths and the fixed-mode override. A block that wired the depth select wrongly would overflow or underflow on the wrong case, and one that did not recentre would keep faulting. Two gap runs that differ only in the correction shift must yield different read counts; a block that ignored the bandwidth input, or inverted the shift, would give equal or reversed counts. Routing vectors check that the lane that is not selected, and both lanes while idle, follow their inputs in the same cycle.

// File: rtl/smooth_pkg.sv
package smooth_pkg;

  // one line bit: positive and negative rail flags
  typedef struct packed {
    logic p;
    logic n;
  } rail_t;

  // which lane carries the elastic store
  typedef enum logic [1:0] {
    LANE_NONE = 2'd0,
    LANE_TX   = 2'd1,
    LANE_RX   = 2'd2,
    LANE_SPR  = 2'd3
  } lane_e;

endpackage

// File: rtl/smooth_buf.sv
module smooth_buf
  import smooth_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        deep,
  input  logic        wr,
  input  rail_t       wdata,
  input  logic        rd,
  output logic [AW:0] occ,
  output logic [AW:0] half,
  output rail_t       rdata,
  output logic        rstb,
  output logic        ovf,
  output logic        unf
);

  localparam int N = 1 << AW;

  rail_t          mem [N];
  logic [AW-1:0]  wp, rp, wp_n, rp_n, mask;
  logic [AW:0]    depth, occ_n;
  logic           deep_q;
  logic           ovf_ev, unf_ev, recentre, ovf_n, unf_n;

  always_comb begin
    depth    = deep ? (AW+1)'(N) : (AW+1)'(N / 2);
    half     = depth >> 1;
    mask     = AW'(depth - 1'b1);
    ovf_ev   = run && wr && !rd && (occ == depth);
    unf_ev   = run && rd && (occ == '0);
    recentre = !run || (deep_q != deep) || ovf_ev || unf_ev;
    wp_n     = wp + AW'(wr);
    if (recentre) begin
      rp_n  = wp_n - half[AW-1:0];
      occ_n = half;
    end else begin
      rp_n  = rp + AW'(rd);
      occ_n = occ + (AW+1)'(wr) - (AW+1)'(rd);
    end
    ovf_n = run && (ovf || ovf_ev);
    unf_n = run && (unf || unf_ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= AW'(N / 2);
      occ    <= (AW+1)'(N / 2);
      deep_q <= 1'b1;
      ovf    <= 1'b0;
      unf    <= 1'b0;
      rdata  <= '0;
      rstb   <= 1'b0;
    end else begin
      wp     <= wp_n;
      rp     <= rp_n;
      occ    <= occ_n;
      deep_q <= deep;
      ovf    <= ovf_n;
      unf    <= unf_n;
      rstb   <= rd;
      if (rd) rdata <= mem[rp & mask];
    end
  end

  // storage has no reset; only written entries are ever trusted
  always_ff @(posedge clk) begin
    if (wr) mem[wp & mask] <= wdata;
  end

  p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (occ <= depth));
  p_idle_centre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (occ == $past(half)));
  p_ovf_centre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (ovf && occ == $past(half)));
  p_unf_centre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_ev |=> (unf && occ == $past(half)));
  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ovf) |=> ovf);
  p_unf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && unf) |=> unf);
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(ovf || unf));

endmodule

// File: rtl/smooth_nco.sv
module smooth_nco #(
  parameter int ACC_W   = 16,
  parameter int NOM_INC = 8192,
  parameter int GAIN    = 8,
  parameter int EW      = 8,
  parameter int SHW     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic signed [EW-1:0] err,
  input  logic [SHW-1:0]       shift,
  output logic                 tick
);

  localparam int SW = ACC_W + 4;
  localparam logic signed [SW-1:0] NOM_S   = SW'(NOM_INC);
  localparam logic signed [SW-1:0] INC_MAX = SW'(1 << (ACC_W - 1));
  localparam logic signed [SW-1:0] INC_MIN = SW'(1);

  logic signed [SW-1:0] ext, term, sum;
  logic [ACC_W-1:0]     acc, acc_n, inc;
  logic [ACC_W:0]       nxt;
  logic                 tick_n;

  always_comb begin
    ext  = SW'(err);
    term = (ext <<< GAIN) >>> shift;
    sum  = NOM_S + term;
    if (sum < INC_MIN)      inc = ACC_W'(INC_MIN);
    else if (sum > INC_MAX) inc = ACC_W'(INC_MAX);
    else                    inc = ACC_W'(sum);
    nxt    = {1'b0, acc} + {1'b0, inc};
    acc_n  = run ? nxt[ACC_W-1:0] : '0;
    tick_n = run && nxt[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc_n;
      tick <= tick_n;
    end
  end

  p_no_back2back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);

endmodule

// File: rtl/gap_smoother.sv
module gap_smoother
  import smooth_pkg::*;
#(
  parameter int AW      = 6,
  parameter int ACC_W   = 16,
  parameter int NOM_INC = 8192,
  parameter int GAIN    = 8,
  parameter int SHW     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [1:0]     lane_sel,
  input  logic           cfg_fixed,
  input  logic           cfg_deep,
  input  logic [SHW-1:0] bw_sel,
  input  logic           tx_stb,
  input  logic           tx_pos,
  input  logic           tx_neg,
  input  logic           rx_stb,
  input  logic           rx_pos,
  input  logic           rx_neg,
  output logic           tx_out_stb,
  output logic           tx_out_pos,
  output logic           tx_out_neg,
  output logic           rx_out_stb,
  output logic           rx_out_pos,
  output logic           rx_out_neg,
  output logic           ovf_flag,
  output logic           unf_flag
);

  localparam int NL = 2;
  localparam int EW = AW + 2;

  lane_e              lane;
  logic [NL-1:0]      lsel, lstb, ostb;
  rail_t              lin  [NL];
  rail_t              lout [NL];
  logic               run, wr, rd, tick, deep, b_stb;
  logic [SHW-1:0]     shift;
  rail_t              wdata, b_data;
  logic [AW:0]        occ, half;
  logic signed [EW-1:0] err;

  assign lin[0] = '{p: tx_pos, n: tx_neg};
  assign lin[1] = '{p: rx_pos, n: rx_neg};
  assign lstb   = {rx_stb, tx_stb};

  always_comb begin
    lane    = lane_e'(lane_sel);
    lsel[0] = (lane == LANE_TX);
    lsel[1] = (lane == LANE_RX);
    run     = en && (|lsel);
    wr      = run && (|(lsel & lstb));
    wdata   = lsel[1] ? lin[1] : lin[0];
    rd      = run && tick;
    deep    = cfg_fixed || cfg_deep;
    shift   = cfg_fixed ? '1 : bw_sel;
    err     = $signed({1'b0, occ}) - $signed({1'b0, half});
  end

  smooth_buf #(.AW(AW)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .deep  (deep),
    .wr    (wr),
    .wdata (wdata),
    .rd    (rd),
    .occ   (occ),
    .half  (half),
    .rdata (b_data),
    .rstb  (b_stb),
    .ovf   (ovf_flag),
    .unf   (unf_flag)
  );

  smooth_nco #(
    .ACC_W   (ACC_W),
    .NOM_INC (NOM_INC),
    .GAIN    (GAIN),
    .EW      (EW),
    .SHW     (SHW)
  ) u_nco (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .err   (err),
    .shift (shift),
    .tick  (tick)
  );

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic held;
    assign held    = run && lsel[i];
    assign ostb[i] = held ? b_stb  : lstb[i];
    assign lout[i] = held ? b_data : lin[i];
  end

  assign tx_out_stb = ostb[0];
  assign tx_out_pos = lout[0].p;
  assign tx_out_neg = lout[0].n;
  assign rx_out_stb = ostb[1];
  assign rx_out_pos = lout[1].p;
  assign rx_out_neg = lout[1].n;

  p_stopped_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !b_stb);
  p_read_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    b_stb |-> $past(run));

endmodule

// File: tb/sim_gap_smoother.sv
module sim_gap_smoother;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  localparam int LOG_N = 1024;

  // {en, lane[1:0], tx{stb,p,n}, rx{stb,p,n}, chk_tx, chk_rx, exp_tx[2:0], exp_rx[2:0]}
  localparam logic [16:0] TBL [NV] = '{
    17'b0_01_110_011_11_110_011,
    17'b1_00_101_110_11_101_110,
    17'b1_11_011_101_11_011_101,
    17'b1_01_111_001_01_000_001,
    17'b1_01_000_111_01_000_111,
    17'b1_10_101_010_10_101_000,
    17'b1_10_010_111_10_010_000,
    17'b0_10_001_100_11_001_100
  };

  logic clk, rst_n, en, cfg_fixed, cfg_deep;
  logic [1:0] lane_sel, bw_sel;
  logic tx_stb, tx_pos, tx_neg, rx_stb, rx_pos, rx_neg;
  logic tx_out_stb, tx_out_pos, tx_out_neg, rx_out_stb, rx_out_pos, rx_out_neg;
  logic ovf_flag, unf_flag;

  gap_smoother u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .lane_sel(lane_sel),
    .cfg_fixed(cfg_fixed), .cfg_deep(cfg_deep), .bw_sel(bw_sel),
    .tx_stb(tx_stb), .tx_pos(tx_pos), .tx_neg(tx_neg),
    .rx_stb(rx_stb), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .tx_out_stb(tx_out_stb), .tx_out_pos(tx_out_pos), .tx_out_neg(tx_out_neg),
    .rx_out_stb(rx_out_stb), .rx_out_pos(rx_out_pos), .rx_out_neg(rx_out_neg),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  int   n_chk, n_bad;
  bit   done;
  logic [1:0] wlog [LOG_N];
  int   wcount, rcount, half_exp;
  bit   mon_on, dly_on;
  logic [7:0] lfsr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // read monitor on the transmit lane
  always @(negedge clk) begin
    if (mon_on && tx_out_stb) begin
      if (dly_on && rcount >= half_exp && (rcount - half_exp) < LOG_N)
        chk({tx_out_pos, tx_out_neg} == wlog[rcount - half_exp],
            "R4 delayed data", int'({tx_out_pos, tx_out_neg}),
            int'(wlog[rcount - half_exp]));
      rcount++;
    end
  end

  task automatic start(input logic dp, input logic fx, input logic [1:0] bw);
    @(negedge clk);
    en = 1'b0; lane_sel = 2'd1; tx_stb = 1'b0; rx_stb = 1'b0;
    cfg_deep = dp; cfg_fixed = fx; bw_sel = bw;
    repeat (2) @(negedge clk);
    wcount = 0; rcount = 0; mon_on = 1'b1;
    half_exp = (dp || fx) ? 32 : 16;
    en = 1'b1;
  endtask

  task automatic put();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_stb = 1'b1; {tx_pos, tx_neg} = lfsr[1:0];
    if (wcount < LOG_N) wlog[wcount] = lfsr[1:0];
    wcount++;
    @(negedge clk);
    tx_stb = 1'b0;
  endtask

  task automatic steady(input int n);
    repeat (n) begin put(); repeat (7) @(negedge clk); end
  endtask

  task automatic gap_reads(input logic dp, input logic fx, input logic [1:0] bw,
                           output int cnt);
    int g0;
    start(dp, fx, bw);
    steady(10);
    g0 = rcount;
    repeat (160) @(negedge clk);
    cnt = rcount - g0;
    chk(unf_flag == 1'b0, "R9 gap no underflow", int'(unf_flag), 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c0, c3, cf, r0;
    n_chk = 0; n_bad = 0; done = 1'b0; lfsr = 8'h5a;
    mon_on = 1'b0; dly_on = 1'b0; wcount = 0; rcount = 0; half_exp = 16;
    rst_n = 1'b0; en = 1'b0; lane_sel = 2'd0; cfg_fixed = 1'b0; cfg_deep = 1'b0;
    bw_sel = 2'd3; tx_stb = 1'b0; tx_pos = 1'b1; tx_neg = 1'b0;
    rx_stb = 1'b1; rx_pos = 1'b0; rx_neg = 1'b1;
    repeat (3) @(negedge clk);
    // reset state
    chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R7 reset flags",
        int'({ovf_flag, unf_flag}), 0);
    chk({tx_out_stb, tx_out_pos, tx_out_neg} == 3'b010, "R1 reset tx pass",
        int'({tx_out_stb, tx_out_pos, tx_out_neg}), 2);
    chk({rx_out_stb, rx_out_pos, rx_out_neg} == 3'b101, "R1 reset rx pass",
        int'({rx_out_stb, rx_out_pos, rx_out_neg}), 5);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // routing and bypass vectors (R1, R2)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      en = TBL[v][16]; lane_sel = TBL[v][15:14];
      {tx_stb, tx_pos, tx_neg} = TBL[v][13:11];
      {rx_stb, rx_pos, rx_neg} = TBL[v][10:8];
      #1;
      if (TBL[v][7])
        chk({tx_out_stb, tx_out_pos, tx_out_neg} == TBL[v][5:3], "R1/R2 tx lane",
            int'({tx_out_stb, tx_out_pos, tx_out_neg}), int'(TBL[v][5:3]));
      if (TBL[v][6])
        chk({rx_out_stb, rx_out_pos, rx_out_neg} == TBL[v][2:0], "R1/R2 rx lane",
            int'({rx_out_stb, rx_out_pos, rx_out_neg}), int'(TBL[v][2:0]));
    end
    @(negedge clk);
    tx_stb = 1'b0; rx_stb = 1'b0;

    // R4 and R8: constant half-depth delay, nominal read rate, 32 entries
    start(1'b0, 1'b0, 2'd3);
    dly_on = 1'b1;
    steady(100);
    chk(rcount >= 95 && rcount <= 105, "R8 read count", rcount, 100);
    chk(!ovf_flag && !unf_flag, "R4 steady no fault", int'({ovf_flag, unf_flag}), 0);
    // R4 with 64 entries
    start(1'b1, 1'b0, 2'd3);
    steady(100);
    chk(rcount >= 95 && rcount <= 105, "R8 read count deep", rcount, 100);
    chk(!ovf_flag && !unf_flag, "R4 deep no fault", int'({ovf_flag, unf_flag}), 0);
    dly_on = 1'b0;

    // R3/R5: burst overflows 32 entries
    start(1'b0, 1'b0, 2'd3);
    repeat (24) put();
    chk(ovf_flag == 1'b1, "R5 overflow set", int'(ovf_flag), 1);
    chk(unf_flag == 1'b0, "R5 no underflow", int'(unf_flag), 0);
    steady(3);
    chk(ovf_flag == 1'b1, "R7 overflow sticky", int'(ovf_flag), 1);
    chk(unf_flag == 1'b0, "R5 recentred no underflow", int'(unf_flag), 0);
    en = 1'b0;
    @(negedge clk);
    chk(ovf_flag == 1'b0, "R7 clear on stop", int'(ovf_flag), 0);
    chk(tx_out_stb == 1'b0, "R1 buffered strobe quiet", int'(tx_out_stb), 0);
    // R3: 64 entries and fixed mode absorb the same burst
    start(1'b1, 1'b0, 2'd3);
    repeat (24) put();
    chk(ovf_flag == 1'b0, "R3 deep absorbs burst", int'(ovf_flag), 0);
    start(1'b0, 1'b1, 2'd0);
    repeat (24) put();
    chk(ovf_flag == 1'b0, "R3 fixed forces deep", int'(ovf_flag), 0);

    // R6: short gap survives, long gap underflows, 32 entries
    start(1'b0, 1'b0, 2'd3);
    steady(10);
    repeat (96) @(negedge clk);
    chk(unf_flag == 1'b0, "R6 12 UI gap", int'(unf_flag), 0);
    start(1'b0, 1'b0, 2'd3);
    steady(10);
    repeat (400) @(negedge clk);
    chk(unf_flag == 1'b1, "R6 long gap underflow", int'(unf_flag), 1);
    r0 = rcount;
    repeat (20) @(negedge clk);
    chk(unf_flag == 1'b1, "R7 underflow sticky", int'(unf_flag), 1);
    chk(rcount > r0, "R8 reads continue", rcount - r0, 1);

    // R9: correction strength changes read count during a gap
    gap_reads(1'b1, 1'b0, 2'd0, c0);
    gap_reads(1'b1, 1'b0, 2'd3, c3);
    gap_reads(1'b0, 1'b1, 2'd0, cf);
    chk(c0 < c3, "R9 strong correction slows reads", c0, c3);
    chk(cf == c3, "R9 fixed uses weakest", cf, c3);

    mon_on = 1'b0;
    en = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule